// File: doc/BRIEF.md
# Continuous-Phase Two-Tone FSK Modulator

This block turns a serial bit stream into a binary frequency-shift-keyed waveform, produced as signed 12-bit samples for a DAC running at the block's own clock. A 32-bit phase accumulator advances every enabled sample by a tuning word. The tuning word is the programmed centre word plus the deviation word for a mark bit, or the centre word minus the deviation word for a space bit. The word that gives an output frequency f at sample rate fs is round(f · 2^32 / fs). For example, a sample clock of 60 MHz or more covers centres from 5 MHz to 21 MHz, with a deviation of 75 kHz that software can trim by ±10 kHz or more.

An internal fractional baud generator adds a fixed increment every enabled sample. It raises `bit_ready` for one cycle each time the sum overflows. On that cycle a bit is taken from the source if `bit_valid` is high; otherwise the previous symbol is sent again. The tuning word switches only at these boundaries, and the phase accumulator is never cleared there, so the waveform keeps a continuous phase across symbols. The default increment paces 39.4 kbit/s at a 120 MHz sample clock.

The amplitude comes from a 256-entry quarter-wave table. The two top phase bits choose whether the table is read backwards and whether the sample is negated. Pulling `en` low forces the output to zero, restarts the baud timer, and freezes the phase.

Top module: `fsk_nco_mod`

## Requirements
- R1: While `rst` is high, and on the first cycle after it is released, `sample_out` is 0 and `bit_ready` is 0. Reset clears the phase, the tuning word, the centre word and the deviation word to 0, and sets the held symbol to space.
- R2: With `m` the top 10 bits of the phase, the sample is round(2047 · sin(2π(m + 0.5)/1024)), rounded away from zero (±1 allowed). It appears on `sample_out` two clock cycles after the phase holds that value. Every one of the 1024 values of `m` is reachable, and the value −2048 never appears.
- R3: On every enabled cycle, the phase advances by the current tuning word modulo 2^32. A sum of centre and deviation above 2^32 − 1, or a difference below 0, wraps modulo 2^32.
- R4: A mark symbol (bit value 1) selects the tuning word centre + deviation. A space symbol (bit value 0) selects centre − deviation.
- R5: Let k be the number of rising edges since `en` was last seen low, or since reset. `bit_ready` is high after edge k exactly when floor(k·INC/2^32) > floor((k−1)·INC/2^32), where INC is the `BAUD_INC` parameter.
- R6: On an edge where `bit_ready` is high, `bit_data` becomes the new symbol only if `bit_valid` is high. Otherwise the held symbol is used again, and `bit_data` has no effect.
- R7: The tuning word changes only on an edge where `bit_ready` is high. A centre or deviation write between boundaries takes effect at the next boundary. The phase is never reset at a boundary.
- R8: After an edge with `en` low, `sample_out` is 0 and `bit_ready` is 0, and the phase is unchanged. When `en` is raised again, the baud count restarts from zero, so with INC = 214748365 the first `bit_ready` follows the 20th enabled edge.
- R9: `cfg_centre_we` loads `cfg_wdata` into the centre word and `cfg_dev_we` loads it into the deviation word, each on the same edge. Both may be written at once with the same value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low zeroes the output, stops the baud timer and freezes the phase |
| cfg_wdata | input | 32 | Write data for the centre and deviation words |
| cfg_centre_we | input | 1 | Load `cfg_wdata` into the centre word |
| cfg_dev_we | input | 1 | Load `cfg_wdata` into the deviation word |
| bit_valid | input | 1 | Source has a bit on `bit_data` |
| bit_data | input | 1 | Next bit, 1 = mark, 0 = space |
| bit_ready | output | 1 | One-cycle symbol boundary; the bit is taken at the next edge if valid |
| sample_out | output | 12 | Signed sine sample for the DAC |

## Verification
A corrupted phase register or tuning word shows on `sample_out` two cycles later, as a sample that breaks from the expected sine. The error then stays, because the phase carries it forward. A baud accumulator that is off by a single count moves a `bit_ready` pulse by a cycle, which the per-edge comparison against the closed-form overflow formula catches at the first boundary it affects. A wrongly held or wrongly taken symbol changes the frequency at the next boundary, and the error is visible in the samples two cycles after that.

// File: rtl/fsk_pkg.sv
package fsk_pkg;

  typedef enum logic {
    SYM_SPACE = 1'b0,
    SYM_MARK  = 1'b1
  } fsk_sym_e;

  typedef logic [1:0] quad_t;

  // Odd quadrants read the quarter-wave table backwards.
  function automatic logic quad_mirror(quad_t q);
    return q[0];
  endfunction

  // The lower half of the cycle is the negative lobe.
  function automatic logic quad_negate(quad_t q);
    return q[1];
  endfunction

endpackage

// File: rtl/fsk_baud_gen.sv
module fsk_baud_gen #(
  parameter int          BAUD_W   = 32,
  parameter int unsigned BAUD_INC = 32'd1410199
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic strobe
);

  localparam logic [BAUD_W:0] INC_EXT = (BAUD_W+1)'(BAUD_INC);

  logic [BAUD_W-1:0] acc_q;
  logic [BAUD_W:0]   sum;
  logic              strobe_q;

  assign sum = {1'b0, acc_q} + INC_EXT;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      acc_q    <= '0;
      strobe_q <= 1'b0;
    end else begin
      acc_q    <= sum[BAUD_W-1:0];
      strobe_q <= sum[BAUD_W];
    end
  end

  assign strobe = strobe_q;

endmodule

// File: rtl/fsk_tone_sel.sv
module fsk_tone_sel
  import fsk_pkg::*;
#(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] cfg_wdata,
  input  logic               cfg_centre_we,
  input  logic               cfg_dev_we,
  input  logic               strobe,
  input  logic               bit_valid,
  input  logic               bit_data,
  output logic [PHASE_W-1:0] tune_word
);

  logic [PHASE_W-1:0] centre_q;
  logic [PHASE_W-1:0] dev_q;
  logic [PHASE_W-1:0] tune_q;
  fsk_sym_e           cur_sym_q;
  fsk_sym_e           next_sym;
  logic [PHASE_W-1:0] mark_word;
  logic [PHASE_W-1:0] space_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      centre_q <= '0;
      dev_q    <= '0;
    end else begin
      if (cfg_centre_we) centre_q <= cfg_wdata;
      if (cfg_dev_we)    dev_q    <= cfg_wdata;
    end
  end

  always_comb begin
    next_sym   = bit_valid ? fsk_sym_e'(bit_data) : cur_sym_q;
    mark_word  = centre_q + dev_q;
    space_word = centre_q - dev_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_sym_q <= SYM_SPACE;
      tune_q    <= '0;
    end else if (strobe) begin
      cur_sym_q <= next_sym;
      tune_q    <= (next_sym == SYM_MARK) ? mark_word : space_word;
    end
  end

  assign tune_word = tune_q;

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int PHASE_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [PHASE_W-1:0] tune_word,
  output logic [PHASE_W-1:0] phase
);

  logic [PHASE_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (en) begin
      phase_q <= phase_q + tune_word;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut
  import fsk_pkg::*;
#(
  parameter int LUT_AW = 8,
  parameter int AMP_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [LUT_AW+1:0]       phase_top,
  output logic signed [AMP_W-1:0] sample
);

  localparam int  DEPTH   = 1 << LUT_AW;
  localparam int  MAG_MAX = (1 << (AMP_W-1)) - 1;
  localparam real PI      = 3.14159265358979;

  logic [AMP_W-1:0] rom [DEPTH];

  // Half-step offset makes the table exactly symmetric under mirroring.
  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      rom[i[LUT_AW-1:0]] = AMP_W'($rtoi(real'(MAG_MAX) *
        $sin(PI / 2.0 * (real'(i) + 0.5) / real'(DEPTH)) + 0.5));
    end
  end

  quad_t             quad;
  logic [LUT_AW-1:0] idx;
  logic [LUT_AW-1:0] addr;

  always_comb begin
    quad = phase_top[LUT_AW+1 -: 2];
    idx  = phase_top[LUT_AW-1:0];
    addr = quad_mirror(quad) ? ~idx : idx;
  end

  logic [AMP_W-1:0] rom_q;
  logic             neg_q;

  always_ff @(posedge clk) begin
    rom_q <= rom[addr];
  end

  always_ff @(posedge clk) begin
    if (rst) neg_q <= 1'b0;
    else     neg_q <= quad_negate(quad);
  end

  logic signed [AMP_W-1:0] mag;
  logic signed [AMP_W-1:0] sample_q;

  assign mag = signed'(rom_q);

  always_ff @(posedge clk) begin
    if (rst || !en) sample_q <= '0;
    else            sample_q <= neg_q ? -mag : mag;
  end

  assign sample = sample_q;

endmodule

// File: rtl/fsk_nco_mod.sv
module fsk_nco_mod #(
  parameter int          PHASE_W  = 32,
  parameter int          LUT_AW   = 8,
  parameter int          AMP_W    = 12,
  parameter int          BAUD_W   = 32,
  parameter int unsigned BAUD_INC = 32'd1410199
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [PHASE_W-1:0]      cfg_wdata,
  input  logic                    cfg_centre_we,
  input  logic                    cfg_dev_we,
  input  logic                    bit_valid,
  input  logic                    bit_data,
  output logic                    bit_ready,
  output logic signed [AMP_W-1:0] sample_out
);

  localparam int TOP_BITS = LUT_AW + 2;

  logic               strobe_w;
  logic [PHASE_W-1:0] tune_word_w;
  logic [PHASE_W-1:0] phase_w;

  fsk_baud_gen #(
    .BAUD_W  (BAUD_W),
    .BAUD_INC(BAUD_INC)
  ) u_baud (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .strobe(strobe_w)
  );

  fsk_tone_sel #(
    .PHASE_W(PHASE_W)
  ) u_tone (
    .clk          (clk),
    .rst          (rst),
    .cfg_wdata    (cfg_wdata),
    .cfg_centre_we(cfg_centre_we),
    .cfg_dev_we   (cfg_dev_we),
    .strobe       (strobe_w),
    .bit_valid    (bit_valid),
    .bit_data     (bit_data),
    .tune_word    (tune_word_w)
  );

  fsk_phase_acc #(
    .PHASE_W(PHASE_W)
  ) u_phase (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .tune_word(tune_word_w),
    .phase    (phase_w)
  );

  fsk_sine_lut #(
    .LUT_AW(LUT_AW),
    .AMP_W (AMP_W)
  ) u_lut (
    .clk      (clk),
    .rst      (rst),
    .en       (en),
    .phase_top(phase_w[PHASE_W-1 -: TOP_BITS]),
    .sample   (sample_out)
  );

  assign bit_ready = strobe_w;

endmodule

// File: rtl/fsk_nco_mod_chk.sv
module fsk_nco_mod_chk #(
  parameter int PHASE_W = 32,
  parameter int AMP_W   = 12
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    en,
  input logic                    bit_ready,
  input logic signed [AMP_W-1:0] sample_out,
  input logic [PHASE_W-1:0]      tune_word,
  input logic [PHASE_W-1:0]      phase
);

  localparam logic signed [AMP_W-1:0] MOST_NEG = {1'b1, {(AMP_W-1){1'b0}}};

  AST_ZERO_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> (sample_out == '0)); // R8

  AST_NO_STROBE_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> !bit_ready); // R8

  AST_PHASE_FROZEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(phase)); // R8

  AST_WORD_ONLY_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    !bit_ready |=> $stable(tune_word)); // R7

  AST_NO_NEG_FULLSCALE: assert property (@(posedge clk) disable iff (rst)
    sample_out != MOST_NEG); // R2

endmodule

bind fsk_nco_mod fsk_nco_mod_chk #(
  .PHASE_W(PHASE_W),
  .AMP_W  (AMP_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .en        (en),
  .bit_ready (bit_ready),
  .sample_out(sample_out),
  .tune_word (tune_word_w),
  .phase     (phase_w)
);

// File: tb/tb_fsk_nco_mod.sv
module tb_fsk_nco_mod;

  localparam int unsigned     TB_INC   = 32'd214748365;
  localparam longint unsigned INC64    = 64'(TB_INC);
  localparam int              WD_LIMIT = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        en;
  logic [31:0] cfg_wdata;
  logic        cfg_centre_we;
  logic        cfg_dev_we;
  logic        bit_valid;
  logic        bit_data;
  logic        bit_ready;
  logic signed [11:0] sample_out;

  always #4 clk = ~clk;

  fsk_nco_mod #(.BAUD_INC(TB_INC)) dut (
    .clk(clk), .rst(rst), .en(en), .cfg_wdata(cfg_wdata),
    .cfg_centre_we(cfg_centre_we), .cfg_dev_we(cfg_dev_we),
    .bit_valid(bit_valid), .bit_data(bit_data),
    .bit_ready(bit_ready), .sample_out(sample_out)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";
  bit    chk_on   = 1'b0;

  function automatic bit strobe_at(longint unsigned k);
    if (k == 0) return 1'b0;
    return ((k * INC64) >> 32) != (((k - 1) * INC64) >> 32);
  endfunction

  function automatic int exp_sine(logic [31:0] ph);
    int  m;
    real s, a;
    int  mag;
    m   = int'(ph[31:22]);
    s   = $sin(2.0 * 3.14159265358979 * (real'(m) + 0.5) / 1024.0);
    a   = (s < 0.0) ? -s : s;
    mag = $rtoi(2047.0 * a + 0.5);
    return (s < 0.0) ? -mag : mag;
  endfunction

  // Reference model built from the requirements.
  logic [31:0]     m_ph, m_ph_d1, m_ph_d2, m_tw, m_cen, m_dev;
  logic            m_bit, m_en_d1, m_rst_d1, nb;
  longint unsigned m_k;

  always @(posedge clk) begin
    m_ph_d2  <= m_ph_d1;
    m_ph_d1  <= m_ph;
    m_en_d1  <= en;
    m_rst_d1 <= rst;
    if (rst) begin
      m_ph <= '0; m_tw <= '0; m_bit <= 1'b0; m_cen <= '0; m_dev <= '0; m_k <= 0;
    end else begin
      if (cfg_centre_we) m_cen <= cfg_wdata;
      if (cfg_dev_we)    m_dev <= cfg_wdata;
      m_k <= en ? m_k + 1 : 0;
      if (en) m_ph <= m_ph + m_tw;
      if (strobe_at(m_k)) begin
        nb    = bit_valid ? bit_data : m_bit;
        m_bit <= nb;
        m_tw  <= nb ? (m_cen + m_dev) : (m_cen - m_dev);
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  logic [15:0]   pattern = 16'hB38E;
  int            bitpos  = 0;
  bit            pend    = 1'b0;
  bit            stream_on = 1'b0;
  logic [1023:0] seen    = '0;

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (chk_on) begin
        longint exp_s;
        longint act_s;
        bit     er;
        er = strobe_at(m_k);
        check(bit_ready == er, "R5", "bit_ready timing", longint'(bit_ready), longint'(er));
        exp_s = (m_rst_d1 || !m_en_d1) ? 0 : longint'(exp_sine(m_ph_d2));
        act_s = longint'(sample_out);
        check((act_s - exp_s <= 1) && (exp_s - act_s <= 1), cur_req, "sample",
              act_s, exp_s);
        if (cur_req == "R2" && m_en_d1 && !m_rst_d1) seen[m_ph_d2[31:22]] = 1'b1;
      end
      if (stream_on) begin
        if (pend) bitpos++;
        bit_valid = 1'b1;
        bit_data  = pattern[bitpos % 16];
        pend      = bit_ready && bit_valid;
      end else begin
        pend = 1'b0;
      end
    end
  endtask

  task automatic wr_cfg(input logic [31:0] v, input bit c, input bit d);
    cfg_wdata     = v;
    cfg_centre_we = c;
    cfg_dev_we    = d;
    run(1);
    cfg_centre_we = 1'b0;
    cfg_dev_we    = 1'b0;
  endtask

  initial begin
    rst = 1'b1; en = 1'b0; cfg_wdata = '0; cfg_centre_we = 1'b0; cfg_dev_we = 1'b0;
    bit_valid = 1'b0; bit_data = 1'b0;
    fork
      begin : tests
        repeat (5) @(negedge clk);
        // R1: reset state at the ports
        check(sample_out == 0, "R1", "sample in reset", longint'(sample_out), 0);
        check(bit_ready == 1'b0, "R1", "ready in reset", longint'(bit_ready), 0);
        rst = 1'b0;
        @(negedge clk);
        check(sample_out == 0, "R1", "sample after reset", longint'(sample_out), 0);
        check(bit_ready == 1'b0, "R1", "ready after reset", longint'(bit_ready), 0);
        chk_on = 1'b1;
        run(2);

        // R2: one table step per sample sweeps every phase index
        cur_req = "R2";
        wr_cfg(32'h0040_0000, 1'b1, 1'b0);
        en = 1'b1; stream_on = 1'b1;
        run(1200);
        check(&seen, "R2", "all 1024 phase indices", longint'($countones(seen)), 1024);

        // R4: mark and space tones from a bit pattern
        cur_req = "R4";
        wr_cfg(32'h0A3D_70A4, 1'b1, 1'b0);
        wr_cfg(32'h009D_4952, 1'b0, 1'b1);
        run(600);

        // R3: word sums and differences wrap modulo 2^32
        cur_req = "R3";
        wr_cfg(32'hF000_0000, 1'b1, 1'b0);
        wr_cfg(32'h2000_0000, 1'b0, 1'b1);
        run(400);

        // R6: bit_data ignored while bit_valid is low
        cur_req = "R6";
        stream_on = 1'b0; bit_valid = 1'b0;
        run(1);
        bit_data = ~m_bit;
        run(200);
        stream_on = 1'b1;

        // R7: mid-symbol write waits for the next boundary
        cur_req = "R7";
        while (!bit_ready) run(1);
        run(3);
        wr_cfg(32'h1234_5678, 1'b1, 1'b0);
        run(60);

        // R8: disable gating, phase freeze and baud restart
        cur_req = "R8";
        en = 1'b0;
        run(1);
        check(sample_out == 0, "R8", "sample while off", longint'(sample_out), 0);
        check(bit_ready == 1'b0, "R8", "ready while off", longint'(bit_ready), 0);
        run(30);
        en = 1'b1;
        begin
          int cnt;
          cnt = 0;
          do begin
            run(1);
            cnt++;
          end while (!bit_ready && cnt < 40);
          check(cnt == 20, "R8", "edges to first boundary after enable", cnt, 20);
        end
        run(100);

        // R9: both words loaded on one edge
        cur_req = "R9";
        wr_cfg(32'h0100_0000, 1'b1, 1'b1);
        run(300);
      end
      begin : watchdog
        repeat (WD_LIMIT) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", WD_LIMIT, 0);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
    $finish;
  end

endmodule